// File: doc/BRIEF.md
# I2C Target Address-Match Responder

This block is the target-side half of a two-wire bus controller. It is active while the local master clock enable is low. It watches SCL and SDA through synchronisers and finds start and stop conditions. It shifts in the first byte after each start and compares the upper seven bits with a programmable own address. When the byte matches, or when it is the general-call byte and general call is allowed, the block acknowledges it. It raises a sticky address-hit flag and reports the direction the bus master asked for.

After the address and after every data byte, the block holds SCL low until software gives a transfer-go pulse. In the receive direction the received byte is presented, and the go pulse also chooses whether to ACK or NAK it. In the transmit direction software supplies the next byte with the go pulse, and the block shifts it out MSB first. A stop condition seen while the block is addressed sets a stop flag. Pending start and stop requests from the local master side are dropped when an address hit occurs. Two enables route the stop and address-hit flags onto a single interrupt line.

Top module: `i2ct_responder`

## Requirements
- R1: After reset, both bus pull outputs are released, every status flag, both pending requests and irq are 0, and the own address is 0x01.
- R2: A first byte whose bits [7:1] equal the own address is acknowledged: SDA is driven low during the ninth clock once software releases the hold. The block sets st_addr_hit, and st_dir takes bit 0 of that byte (1 = the block must transmit).
- R3: A first byte that matches neither the own address nor an allowed general call is not acknowledged. It causes no SCL hold and no flag.
- R4: After a matching address and after every data byte, SCL is held low until a transfer-go pulse arrives.
- R5: In the receive direction, 8 bits are sampled on SCL rising edges, MSB first. They appear on rx_data with st_rx_full set while SCL is held, and st_rx_full clears on the go pulse.
- R6: The nak_sel value given with the go pulse after a received byte chooses the answer: 0 drives SDA low for the ACK clock, and 1 leaves SDA released. After a NAK the block does not hold SCL or answer again until the next start.
- R7: In the transmit direction, st_tx_empty is set while SCL is held before each byte. The go pulse loads tx_byte, and it is shifted out MSB first. A master ACK (SDA low on the ninth clock) leads to another held byte, and a master NAK ends the transfer with SCL and SDA released.
- R8: A stop condition (SDA rising while SCL is high) sets st_stop only if the block was addressed since the last start.
- R9: The byte 0x00 acknowledges and sets st_gcall and st_addr_hit when gc_block is 0. It is ignored entirely when gc_block is 1.
- R10: While mst_clk_en is 1, the block neither drives the bus nor sets any flag.
- R11: An address hit clears start_pend and stop_pend, which are otherwise set by start_req_set and stop_req_set.
- R12: irq is 1 when (st_stop and ie_stop) or (st_addr_hit and ie_addr) is true. flags_clr clears st_addr_hit, st_gcall and st_stop.
- R13: own_addr_we loads own_addr_wd into the own address, and later address matching uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_pull | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull | output | 1 | 1 pulls SDA low |
| mst_clk_en | input | 1 | Master clock enable; target mode when 0 |
| gc_block | input | 1 | 1 ignores the general-call byte |
| own_addr_we | input | 1 | Load strobe for the own address |
| own_addr_wd | input | 7 | New own address |
| xfer_go | input | 1 | One-cycle transfer-go pulse that releases the hold |
| nak_sel | input | 1 | With xfer_go after a received byte: 1 = NAK |
| tx_byte | input | 8 | Byte to send, taken with xfer_go |
| rx_data | output | 8 | Last received data byte |
| start_req_set | input | 1 | Sets the pending start request |
| stop_req_set | input | 1 | Sets the pending stop request |
| start_pend | output | 1 | Pending start request |
| stop_pend | output | 1 | Pending stop request |
| ie_stop | input | 1 | Interrupt enable for st_stop |
| ie_addr | input | 1 | Interrupt enable for st_addr_hit |
| flags_clr | input | 1 | Clears the sticky address, general-call and stop flags |
| st_dir | output | 1 | Direction of the last hit, 1 = block transmits |
| st_addr_hit | output | 1 | Sticky address-hit flag |
| st_gcall | output | 1 | Sticky general-call flag |
| st_stop | output | 1 | Sticky stop-while-addressed flag |
| st_tx_empty | output | 1 | Waiting for a transmit byte |
| st_rx_full | output | 1 | Received byte waiting for service |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that start_req_set and stop_req_set never pulse in the same cycle as an address hit. They also assume that gc_block and mst_clk_en change only while the bus is idle. A further assumption is that the bus master follows the protocol: it changes SDA only while SCL is low, except when it makes a start or a stop. The bench master keeps to these rules. It drives all local inputs on falling clock edges and changes modes only between stop and start. It gives SCL quarter periods of ten clocks, which is far more than the synchroniser latency. It waits on the sensed SCL level, so a held clock simply pauses it.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ADDR,
      S_AHOLD,
      S_AACK,
      S_RXBITS,
      S_RXHOLD,
      S_RXACK,
      S_TXHOLD,
      S_TXBITS,
      S_TXACK
   } tgt_state_e;

endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2ct_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
   import i2ct_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tgt_en,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic          sda_s,
   input  logic [DW-2:0] own_addr,
   input  logic          gc_dis,
   input  logic          xfer_go,
   input  logic          nak_sel,
   input  logic [DW-1:0] tx_byte,
   output logic          scl_hold,
   output logic          sda_low,
   output logic          hit_evt,
   output logic          hit_gc,
   output logic          hit_dir,
   output logic          stop_evt,
   output logic          tx_empty,
   output logic          rx_full,
   output logic [DW-1:0] rx_data
);
   localparam int CW = $clog2(DW + 1);

   tgt_state_e    st;
   logic [DW-1:0] sh;
   logic [CW-1:0] cnt;
   logic          addressed, ack_q, mack;
   logic          own_hit, gc_hit;

   assign own_hit = (sh[DW-1:1] == own_addr);
   assign gc_hit  = !gc_dis && (sh == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  sh <= '0;  cnt <= '0;  addressed <= 1'b0;
         ack_q <= 1'b0;  mack <= 1'b0;  hit_evt <= 1'b0;  hit_gc <= 1'b0;
         hit_dir <= 1'b0;  stop_evt <= 1'b0;  tx_empty <= 1'b0;
         rx_full <= 1'b0;  rx_data <= '0;
      end else begin
         hit_evt  <= 1'b0;
         stop_evt <= 1'b0;
         if (!tgt_en) begin
            st <= S_IDLE;  addressed <= 1'b0;  tx_empty <= 1'b0;  rx_full <= 1'b0;
         end else if (start_det) begin
            st <= S_ADDR;  cnt <= '0;  addressed <= 1'b0;
            tx_empty <= 1'b0;  rx_full <= 1'b0;
         end else if (stop_det) begin
            st <= S_IDLE;  stop_evt <= addressed;  addressed <= 1'b0;
            tx_empty <= 1'b0;  rx_full <= 1'b0;
         end else begin
            case (st)
               S_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[DW-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CW'(DW)) begin
                     if (own_hit || gc_hit) begin
                        st <= S_AHOLD;  hit_evt <= 1'b1;  hit_gc <= gc_hit;
                        hit_dir <= sh[0];  addressed <= 1'b1;
                     end else begin
                        st <= S_IDLE;
                     end
                  end
               end
               S_AHOLD:  if (xfer_go) st <= S_AACK;
               S_AACK: begin
                  if (scl_fall) begin
                     if (hit_dir) begin
                        st <= S_TXHOLD;  tx_empty <= 1'b1;
                     end else begin
                        st <= S_RXBITS;  cnt <= '0;
                     end
                  end
               end
               S_RXBITS: begin
                  if (scl_rise) begin
                     sh  <= {sh[DW-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CW'(DW)) begin
                     rx_data <= sh;  rx_full <= 1'b1;  st <= S_RXHOLD;
                  end
               end
               S_RXHOLD: begin
                  if (xfer_go) begin
                     rx_full <= 1'b0;  ack_q <= ~nak_sel;  st <= S_RXACK;
                  end
               end
               S_RXACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     st  <= ack_q ? S_RXBITS : S_IDLE;
                  end
               end
               S_TXHOLD: begin
                  if (xfer_go) begin
                     tx_empty <= 1'b0;  sh <= tx_byte;  cnt <= '0;  st <= S_TXBITS;
                  end
               end
               S_TXBITS: begin
                  if (scl_fall) begin
                     sh <= {sh[DW-2:0], 1'b1};
                     if (cnt == CW'(DW - 1)) st <= S_TXACK;
                     else                    cnt <= cnt + 1'b1;
                  end
               end
               S_TXACK: begin
                  if (scl_rise) mack <= ~sda_s;
                  else if (scl_fall) begin
                     if (mack) begin
                        st <= S_TXHOLD;  tx_empty <= 1'b1;
                     end else begin
                        st <= S_IDLE;
                     end
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   assign scl_hold = (st == S_AHOLD) || (st == S_RXHOLD) || (st == S_TXHOLD);
   assign sda_low  = (st == S_AACK) || ((st == S_RXACK) && ack_q)
                   || ((st == S_TXBITS) && !sh[DW-1]);
endmodule

// File: rtl/i2ct_responder.sv
module i2ct_responder #(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8,
   parameter int OWN_RST     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_pull,
   output logic              sda_pull,
   input  logic              mst_clk_en,
   input  logic              gc_block,
   input  logic              own_addr_we,
   input  logic [DATA_W-2:0] own_addr_wd,
   input  logic              xfer_go,
   input  logic              nak_sel,
   input  logic [DATA_W-1:0] tx_byte,
   output logic [DATA_W-1:0] rx_data,
   input  logic              start_req_set,
   input  logic              stop_req_set,
   output logic              start_pend,
   output logic              stop_pend,
   input  logic              ie_stop,
   input  logic              ie_addr,
   input  logic              flags_clr,
   output logic              st_dir,
   output logic              st_addr_hit,
   output logic              st_gcall,
   output logic              st_stop,
   output logic              st_tx_empty,
   output logic              st_rx_full,
   output logic              irq
);
   localparam int AW = DATA_W - 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("i2ct_responder: DATA_W must be 8 for 7-bit addressing");
   end
   if (OWN_RST < 0 || OWN_RST >= (1 << AW)) begin : g_bad_own
      $error("i2ct_responder: OWN_RST does not fit the address width");
   end

   logic [AW-1:0] own_addr;
   logic          scl_s, sda_s;
   logic          scl_rise, scl_fall, start_det, stop_det;
   logic          hit_evt, hit_gc, stop_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           own_addr <= AW'(OWN_RST);
      else if (own_addr_we) own_addr <= own_addr_wd;
   end

   i2ct_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
   );

   i2ct_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2ct_engine #(.DW(DATA_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .tgt_en(!mst_clk_en),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
      .own_addr(own_addr), .gc_dis(gc_block),
      .xfer_go(xfer_go), .nak_sel(nak_sel), .tx_byte(tx_byte),
      .scl_hold(scl_pull), .sda_low(sda_pull),
      .hit_evt(hit_evt), .hit_gc(hit_gc), .hit_dir(st_dir), .stop_evt(stop_evt),
      .tx_empty(st_tx_empty), .rx_full(st_rx_full), .rx_data(rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_addr_hit <= 1'b0;  st_gcall <= 1'b0;  st_stop <= 1'b0;
         start_pend  <= 1'b0;  stop_pend <= 1'b0;
      end else begin
         if (hit_evt)                st_addr_hit <= 1'b1;
         else if (flags_clr)         st_addr_hit <= 1'b0;
         if (hit_evt && hit_gc)      st_gcall <= 1'b1;
         else if (flags_clr)         st_gcall <= 1'b0;
         if (stop_evt)               st_stop <= 1'b1;
         else if (flags_clr)         st_stop <= 1'b0;
         if (hit_evt)                start_pend <= 1'b0;
         else if (start_req_set)     start_pend <= 1'b1;
         if (hit_evt)                stop_pend <= 1'b0;
         else if (stop_req_set)      stop_pend <= 1'b1;
      end
   end

   assign irq = (st_stop && ie_stop) || (st_addr_hit && ie_addr);
endmodule

// File: rtl/i2ct_responder_chk.sv
module i2ct_responder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mst_clk_en,
   input logic       gc_block,
   input logic       scl_pull,
   input logic       sda_pull,
   input logic       st_rx_full,
   input logic       st_tx_empty,
   input logic [7:0] rx_data,
   input logic       st_addr_hit,
   input logic       st_gcall,
   input logic       start_pend,
   input logic       stop_pend
);
   // R4
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_rx_full |-> scl_pull);

   // R7
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_tx_empty |-> scl_pull);

   // R5
   one_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_rx_full, st_tx_empty}));

   // R5
   rx_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(st_rx_full) |-> $stable(rx_data));

   // R10
   master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_clk_en && $past(mst_clk_en)) |-> (!scl_pull && !sda_pull));

   // R11
   pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_addr_hit) |-> (!start_pend && !stop_pend));

   // R9
   gc_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gc_block && $past(gc_block)) |-> !$rose(st_gcall));
endmodule

bind i2ct_responder i2ct_responder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mst_clk_en(mst_clk_en), .gc_block(gc_block),
   .scl_pull(scl_pull), .sda_pull(sda_pull), .st_rx_full(st_rx_full),
   .st_tx_empty(st_tx_empty), .rx_data(rx_data), .st_addr_hit(st_addr_hit),
   .st_gcall(st_gcall), .start_pend(start_pend), .stop_pend(stop_pend)
);

// File: tb/test_i2ct_responder.sv
module test_i2ct_responder;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic scl_in, sda_in, scl_pull, sda_pull;
   logic mst_clk_en = 1'b0, gc_block = 1'b0, own_addr_we = 1'b0;
   logic [6:0] own_addr_wd = '0;
   logic xfer_go = 1'b0, nak_sel = 1'b0;
   logic [7:0] tx_byte = '0, rx_data;
   logic start_req_set = 1'b0, stop_req_set = 1'b0, start_pend, stop_pend;
   logic ie_stop = 1'b0, ie_addr = 1'b0, flags_clr = 1'b0;
   logic st_dir, st_addr_hit, st_gcall, st_stop, st_tx_empty, st_rx_full, irq;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign scl_in = m_scl & ~scl_pull;
   assign sda_in = m_sda & ~sda_pull;

   i2ct_responder i_i2ct_responder (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_pull(scl_pull), .sda_pull(sda_pull), .mst_clk_en(mst_clk_en),
      .gc_block(gc_block), .own_addr_we(own_addr_we), .own_addr_wd(own_addr_wd),
      .xfer_go(xfer_go), .nak_sel(nak_sel), .tx_byte(tx_byte), .rx_data(rx_data),
      .start_req_set(start_req_set), .stop_req_set(stop_req_set),
      .start_pend(start_pend), .stop_pend(stop_pend), .ie_stop(ie_stop),
      .ie_addr(ie_addr), .flags_clr(flags_clr), .st_dir(st_dir),
      .st_addr_hit(st_addr_hit), .st_gcall(st_gcall), .st_stop(st_stop),
      .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full), .irq(irq)
   );

   task automatic hc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_go(input bit nak, input logic [7:0] d);
      nak_sel = nak;  tx_byte = d;  xfer_go = 1'b1;
      hc(1);
      xfer_go = 1'b0;
   endtask

   task automatic clear_flags();
      flags_clr = 1'b1;  hc(1);  flags_clr = 1'b0;  hc(1);
   endtask

   task automatic m_start();
      m_sda = 1'b1;  hc(Q);  m_scl = 1'b1;  wait (scl_in);  hc(Q);
      m_sda = 1'b0;  hc(Q);  m_scl = 1'b0;  hc(Q);
   endtask

   task automatic m_stop();
      m_sda = 1'b0;  hc(Q);  m_scl = 1'b1;  wait (scl_in);  hc(Q);
      m_sda = 1'b1;  hc(Q);
   endtask

   task automatic m_bit_out(input logic b);
      m_sda = b;  hc(Q);  m_scl = 1'b1;  wait (scl_in);  hc(Q);
      m_scl = 1'b0;  hc(Q);
   endtask

   task automatic m_send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) m_bit_out(b[i]);
   endtask

   // ninth clock after a byte sent by the master; serve releases the hold
   task automatic m_ack_slot(input bit serve, input bit nak,
                             output logic sda_seen, output logic stretched,
                             output logic rxf, output logic [7:0] rxd);
      m_sda = 1'b1;  hc(Q);  m_scl = 1'b1;  hc(40);
      stretched = !scl_in;  rxf = st_rx_full;  rxd = rx_data;
      if (serve) pulse_go(nak, 8'h00);
      wait (scl_in);  hc(Q / 2);  sda_seen = sda_in;  hc(Q / 2);
      m_scl = 1'b0;  hc(Q);
   endtask

   task automatic m_read_byte(input logic [7:0] d, input bit mack,
                              output logic [7:0] got, output logic stretched,
                              output logic txe);
      m_sda = 1'b1;  hc(Q);  m_scl = 1'b1;  hc(40);
      stretched = !scl_in;  txe = st_tx_empty;
      pulse_go(1'b0, d);
      for (int i = 7; i >= 0; i--) begin
         m_scl = 1'b1;
         wait (scl_in);  hc(Q / 2);  got[i] = sda_in;  hc(Q / 2);
         m_scl = 1'b0;  hc(Q);
      end
      m_bit_out(~mack);
   endtask

   task automatic t_reset();
      chk("R1", "scl_pull", scl_pull, 0);
      chk("R1", "sda_pull", sda_pull, 0);
      chk("R1", "flags", {st_addr_hit, st_gcall, st_stop, st_tx_empty, st_rx_full}, 0);
      chk("R1", "pend/irq", {start_pend, stop_pend, irq}, 0);
   endtask

   task automatic t_write_default_addr();
      logic s, st, rf;  logic [7:0] rd;
      ie_addr = 1'b1;  ie_stop = 1'b1;
      start_req_set = 1'b1;  stop_req_set = 1'b1;  hc(1);
      start_req_set = 1'b0;  stop_req_set = 1'b0;  hc(1);
      chk("R11", "pend set", {start_pend, stop_pend}, 2'b11);
      m_start();
      m_send_byte(8'h02);            // R1 default own address 0x01, write
      m_ack_slot(1'b1, 1'b0, s, st, rf, rd);
      chk("R4", "addr hold", st, 1);
      chk("R2", "addr ack sda", s, 0);
      chk("R2", "addr_hit", st_addr_hit, 1);
      chk("R2", "dir write", st_dir, 0);
      chk("R11", "pend dropped", {start_pend, stop_pend}, 0);
      chk("R12", "irq addr", irq, 1);
      m_send_byte(8'hA5);
      m_ack_slot(1'b1, 1'b0, s, st, rf, rd);
      chk("R4", "byte hold", st, 1);
      chk("R5", "rx_full", rf, 1);
      chk("R5", "rx_data", rd, 8'hA5);
      chk("R6", "ack sda", s, 0);
      chk("R5", "rx_full cleared", st_rx_full, 0);
      m_send_byte(8'h3C);
      m_ack_slot(1'b1, 1'b1, s, st, rf, rd);
      chk("R5", "rx_data 2", rd, 8'h3C);
      chk("R6", "nak sda", s, 1);
      m_send_byte(8'h77);
      m_ack_slot(1'b0, 1'b0, s, st, rf, rd);
      chk("R6", "no hold after nak", st, 0);
      chk("R6", "no ack after nak", s, 1);
      ie_addr = 1'b0;
      m_stop();
      chk("R8", "stop flag", st_stop, 1);
      chk("R12", "irq stop", irq, 1);
      clear_flags();
      chk("R12", "cleared", {st_addr_hit, st_stop, irq}, 0);
      ie_stop = 1'b0;
   endtask

   task automatic t_no_match();
      logic s, st, rf;  logic [7:0] rd;
      own_addr_wd = 7'h2A;  own_addr_we = 1'b1;  hc(1);  own_addr_we = 1'b0;  hc(1);
      m_start();
      m_send_byte(8'h02);            // old address must no longer match
      m_ack_slot(1'b0, 1'b0, s, st, rf, rd);
      chk("R3", "no hold", st, 0);
      chk("R3", "no ack", s, 1);
      chk("R13", "old addr ignored", st_addr_hit, 0);
      m_stop();
      chk("R8", "no stop flag unaddressed", st_stop, 0);
   endtask

   task automatic t_read();
      logic s, st, rf, txe;  logic [7:0] rd, got;
      m_start();
      m_send_byte(8'h55);            // 0x2A, read
      m_ack_slot(1'b1, 1'b0, s, st, rf, rd);
      chk("R13", "new addr ack", s, 0);
      chk("R2", "dir read", st_dir, 1);
      m_read_byte(8'hC3, 1'b1, got, st, txe);
      chk("R7", "tx_empty before byte", txe, 1);
      chk("R4", "tx hold", st, 1);
      chk("R7", "byte 1", got, 8'hC3);
      m_read_byte(8'h5A, 1'b0, got, st, txe);
      chk("R7", "tx_empty again", txe, 1);
      chk("R7", "byte 2", got, 8'h5A);
      hc(5);
      chk("R7", "released after nak", {scl_pull, sda_pull, st_tx_empty}, 0);
      m_stop();
      chk("R8", "stop after read", st_stop, 1);
      clear_flags();
   endtask

   task automatic t_gcall();
      logic s, st, rf;  logic [7:0] rd;
      gc_block = 1'b0;
      m_start();
      m_send_byte(8'h00);
      m_ack_slot(1'b1, 1'b0, s, st, rf, rd);
      chk("R9", "gc ack", s, 0);
      chk("R9", "gc flags", {st_gcall, st_addr_hit}, 2'b11);
      m_stop();
      clear_flags();
      chk("R12", "gc cleared", st_gcall, 0);
      gc_block = 1'b1;  hc(2);
      m_start();
      m_send_byte(8'h00);
      m_ack_slot(1'b0, 1'b0, s, st, rf, rd);
      chk("R9", "blocked no ack", s, 1);
      chk("R9", "blocked no hold", st, 0);
      chk("R9", "blocked no flag", {st_gcall, st_addr_hit}, 0);
      m_stop();
      gc_block = 1'b0;  hc(2);
   endtask

   task automatic t_master_mode();
      logic s, st, rf;  logic [7:0] rd;
      mst_clk_en = 1'b1;  hc(2);
      m_start();
      m_send_byte(8'h54);            // would match 0x2A
      m_ack_slot(1'b0, 1'b0, s, st, rf, rd);
      chk("R10", "no ack", s, 1);
      chk("R10", "no hold", st, 0);
      chk("R10", "no flag", st_addr_hit, 0);
      m_stop();
      chk("R10", "no stop flag", st_stop, 0);
      mst_clk_en = 1'b0;  hc(2);
   endtask

   initial begin
      hc(5);
      rst_n = 1'b1;
      hc(3);
      t_reset();
      t_write_default_addr();
      t_no_match();
      t_read();
      t_gcall();
      t_master_mode();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R4 watchdog: actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule